// File: doc/BRIEF.md
# Compacted State-Restore Sequencer

This block walks the state components of a compacted save area and, for each component that the caller asked for, emits either a load command or an initialize command. A load command carries the byte offset of that component inside the area. A one-cycle start pulse latches the request operand, two control registers and two header bitmaps: a present-state bitmap and a compaction bitmap. From these the block derives the effective request set, the layout mask, the load set and the initialize set. Components 0 to 62 are then visited in ascending order.

Components 0 and 1 sit at fixed locations in the legacy region. Extended components (2 and up) are packed back to back from byte 576. A running offset grows by a component's size only when the compaction bitmap lists that component. Component sizes come from a small table written through a port.

While it runs, the block keeps an in-use bitmap up to date. At the end it publishes a modified bitmap and a restore-info record that was captured at start. Commands leave through a valid/ready handshake. A done pulse marks the end of the walk.

Top module: `cmp_restore_seq`

## Requirements
- R1: The effective request set is (en_ctrl_i OR sup_ext_i) AND req_mask_i. No command is issued for a component whose bit in this set is 0.
- R2: The layout mask is compact_i with bit 63 forced to 0. A component gets a load command (cmd_load_o=1) when it is in the request set, in the layout mask and in present_i. Bit 63 of compact_i has no effect on the commands.
- R3: A requested component gets an initialize command (cmd_load_o=0, cmd_off_o=0) when it is missing from present_i or from the layout mask.
- R4: Commands leave in ascending component order, 0 to 62, and advance only on a cycle with cmd_valid_o and cmd_ready_i both high. While cmd_ready_i is low, cmd_valid_o and every payload field hold steady. No command is valid while busy_o is low.
- R5: A load of component 0 carries offset 0. A load of component 1 carries offset 160.
- R6: The first extended component in the layout mask starts at offset 576. For components 2 to 62, the running offset grows by the table size of each component whose layout-mask bit is set, whether that component is loaded, initialized or not requested.
- R7: init_csr_o reads 0x1F80 while an initialize command for component 1 is valid, and 0 at all other times.
- R8: An accepted load sets in_use_o for that component. An accepted initialize clears it. All other bits keep their value.
- R9: done_o is high for exactly one cycle, one cycle after component 62 is handled. In that cycle busy_o is already low and modified_o equals NOT of the request set. With no commands to issue, done_o rises 63 cycles after the start edge.
- R10: At start, info_priv_o, info_nonroot_o, info_addr_o and info_compact_o capture priv_i, nonroot_i, area_addr_i and compact_i unchanged.
- R11: start_i and all mask and info inputs are sampled only on the start edge. Changes to them while busy_o is high do not affect the commands or the results.
- R12: After reset the block is idle, and busy_o, cmd_valid_o, done_o, in_use_o, modified_o and all info outputs are 0.
- R13: A write with size_we_i stores size_val_i as the size of component size_idx_i. Later offsets use the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; latches all masks and info inputs |
| req_mask_i | input | 64 | Request operand |
| en_ctrl_i | input | 64 | Enable-control register |
| sup_ext_i | input | 64 | Supervisor-extension register |
| present_i | input | 64 | Present-state bitmap from the header |
| compact_i | input | 64 | Compaction bitmap from the header |
| priv_i | input | 2 | Privilege level to record |
| nonroot_i | input | 1 | Non-root-mode flag to record |
| area_addr_i | input | 64 | Linear address of the save area |
| size_we_i | input | 1 | Size table write enable |
| size_idx_i | input | 6 | Size table write index |
| size_val_i | input | 16 | Size in bytes to write |
| busy_o | output | 1 | Sequence in progress |
| cmd_valid_o | output | 1 | Command valid |
| cmd_ready_i | input | 1 | Command accepted by the consumer |
| cmd_load_o | output | 1 | 1 = load, 0 = initialize |
| cmd_comp_o | output | 6 | Component number |
| cmd_off_o | output | 24 | Byte offset of a load; 0 for an initialize |
| init_csr_o | output | 32 | Control/status reset value for a component 1 initialize |
| done_o | output | 1 | End-of-sequence pulse |
| in_use_o | output | 64 | In-use tracking bitmap |
| modified_o | output | 64 | Modified tracking bitmap |
| info_priv_o | output | 2 | Recorded privilege level |
| info_nonroot_o | output | 1 | Recorded non-root flag |
| info_addr_o | output | 64 | Recorded save-area address |
| info_compact_o | output | 64 | Recorded compaction bitmap |

## Verification
On every cycle the assertions check the handshake rules: payload holds during a stall, no command appears while idle, and component numbers stay in range. They also check that every extended load offset is at least 576, that the 0x1F80 value goes with each component 1 initialize, that in_use_o follows each accepted command in the next cycle, and that done_o is a single pulse that arrives after busy_o drops. Only the bench scenarios can show the mask algebra and the offset sums. These include a request set masked off entirely, bit 63 of the compaction bitmap toggled, components present but left out of the layout, and layout bits set on components that were not requested. The same holds for whether inputs changed mid-sequence are ignored and for the modified bitmap and info record at the end.

// File: rtl/cmp_restore_pkg.sv
package cmp_restore_pkg;
  localparam int unsigned MASKW     = 64;
  localparam int unsigned LAST_COMP = 62;
  localparam int unsigned FIRST_EXT = 2;
  localparam int unsigned EXT_BASE  = 576;
  localparam logic [31:0] CSR_INIT  = 32'h0000_1F80;

  typedef enum logic {ST_IDLE, ST_RUN} seq_st_e;

  typedef struct packed {
    logic [1:0]       priv;
    logic             nonroot;
    logic [MASKW-1:0] addr;
    logic [MASKW-1:0] compact;
  } rinfo_t;
endpackage

// File: rtl/cmp_mask_calc.sv
module cmp_mask_calc #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] sup_i,
  input  logic [W-1:0] present_i,
  input  logic [W-1:0] compact_i,
  output logic [W-1:0] rfbm_o,
  output logic [W-1:0] fmt_o,
  output logic [W-1:0] load_o,
  output logic [W-1:0] init_o
);
  always_comb begin
    rfbm_o        = (en_i | sup_i) & req_i;
    fmt_o         = compact_i;
    fmt_o[W-1]    = 1'b0;
    load_o        = fmt_o & rfbm_o & present_i;
    init_o        = rfbm_o & (~present_i | ~fmt_o);
  end
endmodule

// File: rtl/cmp_size_tbl.sv
module cmp_size_tbl #(
  parameter int unsigned N   = 64,
  parameter int unsigned IW  = 6,
  parameter int unsigned SZW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [IW-1:0]  widx_i,
  input  logic [SZW-1:0] wdata_i,
  input  logic [IW-1:0]  ridx_i,
  output logic [SZW-1:0] rdata_o
);
  logic [SZW-1:0] mem_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N); i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/cmp_off_acc.sv
module cmp_off_acc #(
  parameter int unsigned OFFW = 24,
  parameter int unsigned SZW  = 16,
  parameter int unsigned BASE = 576
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            adv_i,
  input  logic [SZW-1:0]  size_i,
  output logic [OFFW-1:0] off_o
);
  logic [OFFW-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     off_q <= OFFW'(BASE);
    else if (clr_i)  off_q <= OFFW'(BASE);
    else if (adv_i)  off_q <= off_q + OFFW'(size_i);
  end

  assign off_o = off_q;
endmodule

// File: rtl/cmp_restore_seq.sv
module cmp_restore_seq
  import cmp_restore_pkg::*;
#(
  parameter int unsigned IDXW     = 6,
  parameter int unsigned SZW      = 16,
  parameter int unsigned OFFW     = 24,
  parameter int unsigned LEG_OFF0 = 0,
  parameter int unsigned LEG_OFF1 = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [63:0]       req_mask_i,
  input  logic [63:0]       en_ctrl_i,
  input  logic [63:0]       sup_ext_i,
  input  logic [63:0]       present_i,
  input  logic [63:0]       compact_i,
  input  logic [1:0]        priv_i,
  input  logic              nonroot_i,
  input  logic [63:0]       area_addr_i,
  input  logic              size_we_i,
  input  logic [IDXW-1:0]   size_idx_i,
  input  logic [SZW-1:0]    size_val_i,
  output logic              busy_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_load_o,
  output logic [IDXW-1:0]   cmd_comp_o,
  output logic [OFFW-1:0]   cmd_off_o,
  output logic [31:0]       init_csr_o,
  output logic              done_o,
  output logic [63:0]       in_use_o,
  output logic [63:0]       modified_o,
  output logic [1:0]        info_priv_o,
  output logic              info_nonroot_o,
  output logic [63:0]       info_addr_o,
  output logic [63:0]       info_compact_o
);
  localparam int unsigned NCOMP = 1 << IDXW;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(LAST_COMP);
  localparam logic [IDXW-1:0] EXT_IDX  = IDXW'(FIRST_EXT);

  seq_st_e          state_q;
  logic [IDXW-1:0]  idx_q;
  logic [MASKW-1:0] rfbm_q, fmt_q, load_q, init_q, in_use_q, mod_q;
  rinfo_t           info_q;
  logic             done_q;

  logic [MASKW-1:0] rfbm_d, fmt_d, load_d, init_d;
  logic [SZW-1:0]   cur_size;
  logic [OFFW-1:0]  ext_off;
  logic             run, take, cur_load, cur_init, need, fire, adv, off_adv;

  cmp_mask_calc #(.W(MASKW)) u_mask (
    .req_i     (req_mask_i),
    .en_i      (en_ctrl_i),
    .sup_i     (sup_ext_i),
    .present_i (present_i),
    .compact_i (compact_i),
    .rfbm_o    (rfbm_d),
    .fmt_o     (fmt_d),
    .load_o    (load_d),
    .init_o    (init_d)
  );

  cmp_size_tbl #(.N(NCOMP), .IW(IDXW), .SZW(SZW)) u_size (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (size_we_i),
    .widx_i  (size_idx_i),
    .wdata_i (size_val_i),
    .ridx_i  (idx_q),
    .rdata_o (cur_size)
  );

  assign run      = (state_q == ST_RUN);
  assign take     = !run && start_i;
  assign cur_load = load_q[idx_q];
  assign cur_init = init_q[idx_q];
  assign need     = cur_load | cur_init;
  assign fire     = run && need && cmd_ready_i;
  assign adv      = run && (!need || cmd_ready_i);
  // offset walks every layout-listed extended component, loaded or not
  assign off_adv  = adv && (idx_q >= EXT_IDX) && fmt_q[idx_q];

  cmp_off_acc #(.OFFW(OFFW), .SZW(SZW), .BASE(EXT_BASE)) u_off (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (take),
    .adv_i  (off_adv),
    .size_i (cur_size),
    .off_o  (ext_off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rfbm_q  <= '0;
      fmt_q   <= '0;
      load_q  <= '0;
      init_q  <= '0;
      mod_q   <= '0;
      info_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        state_q         <= ST_RUN;
        idx_q           <= '0;
        rfbm_q          <= rfbm_d;
        fmt_q           <= fmt_d;
        load_q          <= load_d;
        init_q          <= init_d;
        info_q.priv     <= priv_i;
        info_q.nonroot  <= nonroot_i;
        info_q.addr     <= area_addr_i;
        info_q.compact  <= compact_i;
      end else if (adv) begin
        if (idx_q == LAST_IDX) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          mod_q   <= ~rfbm_q;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   in_use_q <= '0;
    else if (fire) in_use_q[idx_q] <= cur_load;
  end

  always_comb begin
    cmd_off_o = '0;
    if (cur_load) begin
      if (idx_q == '0)                  cmd_off_o = OFFW'(LEG_OFF0);
      else if (idx_q == IDXW'(1))       cmd_off_o = OFFW'(LEG_OFF1);
      else                              cmd_off_o = ext_off;
    end
  end

  assign busy_o         = run;
  assign cmd_valid_o    = run && need;
  assign cmd_load_o     = cur_load;
  assign cmd_comp_o     = idx_q;
  assign init_csr_o     = (run && cur_init && idx_q == IDXW'(1)) ? CSR_INIT : 32'h0;
  assign done_o         = done_q;
  assign in_use_o       = in_use_q;
  assign modified_o     = mod_q;
  assign info_priv_o    = info_q.priv;
  assign info_nonroot_o = info_q.nonroot;
  assign info_addr_o    = info_q.addr;
  assign info_compact_o = info_q.compact;
endmodule

// File: rtl/cmp_restore_chk.sv
module cmp_restore_chk #(
  parameter int unsigned IDXW = 6,
  parameter int unsigned OFFW = 24
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            cmd_valid_o,
  input logic            cmd_ready_i,
  input logic            cmd_load_o,
  input logic [IDXW-1:0] cmd_comp_o,
  input logic [OFFW-1:0] cmd_off_o,
  input logic [31:0]     init_csr_o,
  input logic            done_o,
  input logic [63:0]     in_use_o
);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_comp_o)
      && $stable(cmd_off_o) && $stable(cmd_load_o));

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !cmd_valid_o);

  p_comp_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> cmd_comp_o <= IDXW'(62));

  p_ext_floor_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_load_o && cmd_comp_o >= IDXW'(2) |-> cmd_off_o >= OFFW'(576));

  p_csr_init_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_load_o && cmd_comp_o == IDXW'(1) |-> init_csr_o == 32'h1F80);

  p_use_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i && cmd_load_o |=> in_use_o[$past(cmd_comp_o)]);

  p_use_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_ready_i && !cmd_load_o |=> !in_use_o[$past(cmd_comp_o)]);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind cmp_restore_seq cmp_restore_chk #(.IDXW(IDXW), .OFFW(OFFW)) u_chk (.*);

// File: tb/sim_cmp_restore_seq.sv
module sim_cmp_restore_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] req_mask_i = '0, en_ctrl_i = '0, sup_ext_i = '0, present_i = '0, compact_i = '0;
  logic [1:0]  priv_i = '0;
  logic        nonroot_i = 1'b0;
  logic [63:0] area_addr_i = '0;
  logic        size_we_i = 1'b0;
  logic [5:0]  size_idx_i = '0;
  logic [15:0] size_val_i = '0;
  logic        cmd_ready_i = 1'b0;
  logic        busy_o, cmd_valid_o, cmd_load_o, done_o, info_nonroot_o;
  logic [5:0]  cmd_comp_o;
  logic [23:0] cmd_off_o;
  logic [31:0] init_csr_o;
  logic [63:0] in_use_o, modified_o, info_addr_o, info_compact_o;
  logic [1:0]  info_priv_o;

  int checks = 0;
  int errors = 0;
  int unsigned seed_v;

  logic [15:0] sz_m [64];
  logic [63:0] use_m = '0;
  logic [5:0]  e_comp [63];
  logic        e_load [63];
  logic [23:0] e_off  [63];
  int          n_exp;

  always #10 clk_i = ~clk_i;

  cmp_restore_seq u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_size(input int idx, input logic [15:0] v);
    @(negedge clk_i);
    size_we_i = 1'b1; size_idx_i = 6'(idx); size_val_i = v;
    @(negedge clk_i);
    size_we_i = 1'b0;
    sz_m[idx] = v;
  endtask

  task automatic build_exp(input logic [63:0] rf, input logic [63:0] cm, input logic [63:0] pr);
    logic [63:0] fm;
    int off;
    fm = cm; fm[63] = 1'b0;
    off = 576; n_exp = 0;
    for (int i = 0; i <= 62; i++) begin
      bit lo, in;
      lo = fm[i] & rf[i] & pr[i];
      in = rf[i] & (~pr[i] | ~fm[i]);
      if (lo || in) begin
        e_comp[n_exp] = 6'(i);
        e_load[n_exp] = lo;
        e_off[n_exp]  = !lo ? 24'd0 : (i == 0) ? 24'd0 : (i == 1) ? 24'd160 : 24'(off);
        n_exp++;
      end
      if (i >= 2 && fm[i]) off += int'(sz_m[i]);
    end
  endtask

  task automatic run_case(input logic [63:0] rq, input logic [63:0] en, input logic [63:0] sp,
                          input logic [63:0] pr, input logic [63:0] cm, input bit full_rdy);
    logic [63:0] rf, addr;
    logic [1:0]  pv;
    logic        nr;
    int k, cyc;
    bit seen;
    rf = (en | sp) & rq;
    build_exp(rf, cm, pr);
    addr = {$urandom, $urandom}; pv = 2'($urandom); nr = 1'($urandom);
    @(negedge clk_i);
    req_mask_i = rq; en_ctrl_i = en; sup_ext_i = sp; present_i = pr; compact_i = cm;
    priv_i = pv; nonroot_i = nr; area_addr_i = addr; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R11: scramble inputs while busy
    req_mask_i = {$urandom, $urandom}; en_ctrl_i = '1; sup_ext_i = {$urandom, $urandom};
    present_i = {$urandom, $urandom}; compact_i = {$urandom, $urandom};
    priv_i = ~pv; nonroot_i = ~nr; area_addr_i = ~addr;
    k = 0; cyc = 0; seen = 0;
    while (!seen && cyc < 1000) begin
      if (done_o) begin
        seen = 1;
        start_i = 1'b0;
      end else begin
        cyc++;
        cmd_ready_i = full_rdy ? 1'b1 : 1'($urandom % 2);
        start_i = 1'($urandom % 4 == 0);
        if (cmd_valid_o && cmd_ready_i) begin
          if (k < n_exp) begin
            logic [31:0] ecsr;
            ecsr = (!e_load[k] && e_comp[k] == 6'd1) ? 32'h1F80 : 32'h0;
            chk(cmd_comp_o == e_comp[k], "R4 R1 order comp", 64'(cmd_comp_o), 64'(e_comp[k]));
            chk(cmd_load_o == e_load[k], "R2 R3 cmd kind", 64'(cmd_load_o), 64'(e_load[k]));
            chk(cmd_off_o == e_off[k], "R5 R6 R13 offset", 64'(cmd_off_o), 64'(e_off[k]));
            chk(init_csr_o == ecsr, "R7 csr value", 64'(init_csr_o), 64'(ecsr));
            use_m[e_comp[k]] = e_load[k];
          end else begin
            chk(1'b0, "R1 extra command", 64'(cmd_comp_o), 64'(n_exp));
          end
          k++;
        end
        @(negedge clk_i);
      end
    end
    cmd_ready_i = 1'b0;
    chk(seen, "R9 done seen", 64'(seen), 64'd1);
    chk(k == n_exp, "R1 R4 command count", 64'(k), 64'(n_exp));
    chk(!busy_o, "R9 idle at done", 64'(busy_o), 64'd0);
    chk(modified_o == ~rf, "R9 modified", modified_o, ~rf);
    chk(in_use_o == use_m, "R8 in-use", in_use_o, use_m);
    chk(info_addr_o == addr && info_priv_o == pv && info_nonroot_o == nr,
        "R10 info fields", info_addr_o, addr);
    chk(info_compact_o == cm, "R10 info compact", info_compact_o, cm);
    if (n_exp == 0) chk(cyc == 63, "R9 latency", 64'(cyc), 64'd63);
    @(negedge clk_i);
    chk(!done_o, "R9 single pulse", 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] all1;
    seed_v = $urandom(32'h5EED_1234);
    all1 = '1;
    for (int i = 0; i < 64; i++) sz_m[i] = '0;
    repeat (3) @(negedge clk_i);
    // R12
    chk(!busy_o && !cmd_valid_o && !done_o, "R12 idle", {busy_o, cmd_valid_o, done_o}, 0);
    chk(in_use_o == 0 && modified_o == 0, "R12 bitmaps", in_use_o | modified_o, 0);
    chk(info_addr_o == 0 && info_compact_o == 0 && info_priv_o == 0 && !info_nonroot_o,
        "R12 info", info_addr_o | info_compact_o, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 64; i++) wr_size(i, 16'(($urandom % 64) * 64 + 64));
    // R1: empty request set
    run_case(all1, '0, '0, all1, all1, 1'b1);
    // all loads, bit 63 set vs clear (R2)
    run_case(all1, all1, '0, all1, all1, 1'b1);
    run_case(all1, '0, all1, all1, all1 >> 1, 1'b0);
    // R3: nothing present
    run_case(all1, all1, '0, '0, all1, 1'b0);
    // R3 and R6: present but outside layout, sparse layout
    run_case(all1, all1, '0, all1, 64'h8000_0F0F_00F0_A5A3, 1'b0);
    // R6: layout bits set on unrequested components
    run_case(64'h5555_5555_5555_5557, all1, '0, all1, all1, 1'b0);
    // R13: rewrite sizes then repeat
    for (int i = 2; i < 10; i++) wr_size(i, 16'(i * 100));
    run_case(all1, all1, '0, all1, 64'h0000_0000_0000_03FF, 1'b1);
    for (int n = 0; n < 25; n++) begin
      run_case({$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
               {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom % 3 == 0));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule